// File: doc/BRIEF.md
# Function-group pad assignment selector

This block hands whole sets of chip pads to on-chip peripherals with one register write. A 99-pad space (pads 0 to 98) is shared by three peripheral groups: a serial-flash interface with two alternative pad sets, UART channel 0, and an eMMC interface. Software writes a select register over a single-cycle write/read port. Each field in it either leaves its group's pads free or claims a fixed pad set for that group. The pad drivers, the peripherals themselves and any per-signal routing fabric sit outside the block. They use the two per-pad outputs: a claimed flag and an owner code.

Two enabled groups may want the same pad. The eMMC set and the second serial-flash set share four pads. When that happens, the group with the lower index takes the pad. The block also raises a sticky conflict flag, which software reads and clears through the status register.

Owner codes:
- 0: pad free.
- 1: serial flash (group index 0).
- 2: UART channel 0 (group index 1).
- 3: eMMC (group index 2).

The per-pad outputs are registered from the select register, so they follow a write after two clock edges: the first edge loads the select register and the second loads the outputs.

Top module: `pinsel_top`

## Requirements
- R1: While reset is asserted and after it is released, the select register reads 0, no pad is claimed, every owner code is 0 and the conflict flag is 0.
- R2: Serial-flash select (address 0, bits 1:0) equal to 1 claims pads 83, 84, 86 and 87 with owner code 1, and no other pad.
- R3: Serial-flash select equal to 2 claims pads 76, 78, 79 and 81 with owner code 1.
- R4: A serial-flash select of 0 or 3 claims no pad. With all other fields clear, no pad is claimed.
- R5: The UART-0 enable (address 0, bit 2) claims pads 88 and 89 with owner code 2.
- R6: The eMMC enable (address 0, bit 3) claims pads 72 through 81 with owner code 3.
- R7: When serial-flash select 2 and the eMMC enable are both set, pads 76, 78, 79 and 81 carry owner code 1 (lower group index wins), and pads 72 to 75, 77 and 80 carry owner code 3.
- R8: Whenever two enabled groups claim a common pad, the conflict flag (output conflict_o, and bit 0 at address 1) is set on the same edge that updates the pad outputs. It stays set after the overlap is removed.
- R9: Writing 1 to bit 0 at address 1 clears the conflict flag, and writing 0 there has no effect. While an overlap persists, setting takes precedence over clearing.
- R10: A write to address 0 is read back right after the edge that captures it. The pad outputs change one clock edge later.
- R11: Address 0 reads back only bits 3:0, and its upper bits read 0. Writes to addresses 2 and 3 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pad_claimed_o | output | 99 | One bit per pad, set when some group owns the pad |
| pad_owner_o | output | 198 | Two bits per pad (pad p at bits 2p+1:2p), owner code |
| conflict_o | output | 1 | Sticky flag for overlapping group claims |

## Verification
The bench targets the shared pads between the second serial-flash set and eMMC. A wrong priority order would hand pads 76, 78, 79 and 81 to eMMC. It also checks that the reserved flash value 3 claims nothing, where a decoder keyed on single bits would claim both pad sets.

For the sticky flag, the bench removes the overlap, writes a zero, and clears while the overlap is still live. A level flag would drop too early, and clear-over-set priority would lose a live conflict.

The bench samples between the select readback and the pad update, which catches outputs that are a cycle early or late. It also writes to unmapped addresses and to the unused select bits, which catches address decoding that is too loose.

// File: rtl/pinsel_pkg.sv
package pinsel_pkg;
  localparam int unsigned NUM_PADS   = 99;
  localparam int unsigned NUM_GROUPS = 3;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned OWN_W      = $clog2(NUM_GROUPS + 1);

  // group indices double as priority: lower index wins a shared pad
  localparam int unsigned GRP_FLASH = 0;
  localparam int unsigned GRP_UART0 = 1;
  localparam int unsigned GRP_EMMC  = 2;

  typedef logic [NUM_PADS-1:0] padmask_t;
  typedef logic [SEL_W-1:0]    grpsel_t;

  // pad set claimed by one group for a given select value
  function automatic padmask_t group_pads(int unsigned grp, grpsel_t sel);
    padmask_t m;
    m = '0;
    case (grp)
      GRP_FLASH: begin
        if (sel == 2'd1) begin
          m[83] = 1'b1; m[84] = 1'b1; m[86] = 1'b1; m[87] = 1'b1;
        end else if (sel == 2'd2) begin
          m[76] = 1'b1; m[78] = 1'b1; m[79] = 1'b1; m[81] = 1'b1;
        end
      end
      GRP_UART0: begin
        if (sel[0]) begin
          m[88] = 1'b1; m[89] = 1'b1;
        end
      end
      GRP_EMMC: begin
        if (sel[0]) begin
          for (int p = 72; p <= 81; p++) m[p] = 1'b1;
        end
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pinsel_regs.sv
module pinsel_regs
  import pinsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic                             overlap_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_GROUPS-1:0][SEL_W-1:0] sel_o,
  output logic                             sticky_o
);
  localparam int unsigned SELREG_W  = SEL_W + (NUM_GROUPS - 1);
  localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

  logic [SELREG_W-1:0] sel_q, sel_d;
  logic                sel_en;
  logic                sticky_q, sticky_d;
  logic                clr_req;

  always_comb begin
    sel_en   = wr_en_i && (addr_i == ADDR_SEL);
    sel_d    = wdata_i[SELREG_W-1:0];
    clr_req  = wr_en_i && (addr_i == ADDR_STAT) && wdata_i[0];
    sticky_d = overlap_i | (sticky_q & ~clr_req);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      sticky_q <= sticky_d;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_SEL:  rdata_o = DATA_W'(sel_q);
      ADDR_STAT: rdata_o = DATA_W'(sticky_q);
      default:   rdata_o = '0;
    endcase
  end

  // field unpacking: flash uses two bits, later groups one bit each
  always_comb begin
    sel_o[GRP_FLASH] = sel_q[SEL_W-1:0];
    for (int g = 1; g < int'(NUM_GROUPS); g++) begin
      sel_o[g] = SEL_W'(sel_q[SEL_W + g - 1]);
    end
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/pinsel_decode.sv
module pinsel_decode
  import pinsel_pkg::*;
(
  input  logic [NUM_GROUPS-1:0][SEL_W-1:0]    sel_i,
  output logic [NUM_GROUPS-1:0][NUM_PADS-1:0] claims_o
);
  for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_grp
    assign claims_o[g] = group_pads(g, sel_i[g]);
  end
endmodule

// File: rtl/pinsel_arbiter.sv
module pinsel_arbiter
  import pinsel_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_GROUPS-1:0][NUM_PADS-1:0] claims_i,
  output logic [NUM_PADS-1:0]                 claimed_o,
  output logic [NUM_PADS*OWN_W-1:0]           owner_o,
  output logic                                overlap_o
);
  logic [NUM_PADS-1:0]       claimed_d, claimed_q;
  logic [NUM_PADS*OWN_W-1:0] owner_d, owner_q;
  logic                      upd_en;

  always_comb begin
    claimed_d = '0;
    owner_d   = '0;
    overlap_o = 1'b0;
    for (int g = int'(NUM_GROUPS) - 1; g >= 0; g--) begin
      claimed_d = claimed_d | claims_i[g];
      for (int p = 0; p < int'(NUM_PADS); p++) begin
        if (claims_i[g][p]) owner_d[p*OWN_W +: OWN_W] = OWN_W'(g + 1);
      end
    end
    for (int i = 0; i < int'(NUM_GROUPS); i++) begin
      for (int j = i + 1; j < int'(NUM_GROUPS); j++) begin
        overlap_o = overlap_o | (|(claims_i[i] & claims_i[j]));
      end
    end
  end

  assign upd_en = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claimed_q <= '0;
      owner_q   <= '0;
    end else if (upd_en) begin
      claimed_q <= claimed_d;
      owner_q   <= owner_d;
    end
  end

  assign claimed_o = claimed_q;
  assign owner_o   = owner_q;
endmodule

// File: rtl/pinsel_top.sv
module pinsel_top
  import pinsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_PADS-1:0]       pad_claimed_o,
  output logic [NUM_PADS*OWN_W-1:0] pad_owner_o,
  output logic                      conflict_o
);
  logic [1:0]                          rst_sync_q;
  logic                                rst_sync_n;
  logic [NUM_GROUPS-1:0][SEL_W-1:0]    sel_bits;
  logic [NUM_GROUPS-1:0][NUM_PADS-1:0] claims;
  logic                                overlap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pinsel_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .overlap_i (overlap),
    .rdata_o   (rdata_o),
    .sel_o     (sel_bits),
    .sticky_o  (conflict_o)
  );

  pinsel_decode u_dec (
    .sel_i    (sel_bits),
    .claims_o (claims)
  );

  pinsel_arbiter u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .claims_i  (claims),
    .claimed_o (pad_claimed_o),
    .owner_o   (pad_owner_o),
    .overlap_o (overlap)
  );
endmodule

// File: rtl/pinsel_checker.sv
module pinsel_checker
  import pinsel_pkg::*;
(
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [1:0]                       addr_i,
  input logic [7:0]                       wdata_i,
  input logic [NUM_GROUPS-1:0][SEL_W-1:0] sel_i,
  input logic                             overlap_i,
  input logic [NUM_PADS-1:0]              pad_claimed_o,
  input logic [NUM_PADS*OWN_W-1:0]        pad_owner_o,
  input logic                             conflict_o
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (addr_i == 2'd1) && wdata_i[0];

  AST_UART_PADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[GRP_UART0][0] |=> (pad_claimed_o[88] && pad_claimed_o[89])); // R5

  AST_NO_CLAIM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_i[GRP_FLASH] == 2'd0 || sel_i[GRP_FLASH] == 2'd3) &&
     sel_i[GRP_UART0] == '0 && sel_i[GRP_EMMC] == '0) |=> (pad_claimed_o == '0)); // R4

  AST_LOW_INDEX_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[GRP_FLASH] == 2'd2 && sel_i[GRP_EMMC][0]) |=>
      (pad_owner_o[76*OWN_W +: OWN_W] == 2'd1 && pad_owner_o[72*OWN_W +: OWN_W] == 2'd3)); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !clr_wr) |=> conflict_o); // R8

  AST_CONFLICT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conflict_o) |-> $past(overlap_i)); // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !overlap_i) |=> !conflict_o); // R9
endmodule

bind pinsel_top pinsel_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_sync_n),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .sel_i         (sel_bits),
  .overlap_i     (overlap),
  .pad_claimed_o (pad_claimed_o),
  .pad_owner_o   (pad_owner_o),
  .conflict_o    (conflict_o)
);

// File: tb/tb_pinsel_top.sv
module tb_pinsel_top;
  localparam int NP = 99;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          wr_en_i;
  logic [1:0]    addr_i;
  logic [7:0]    wdata_i;
  logic [7:0]    rdata_o;
  logic [NP-1:0] pad_claimed_o;
  logic [2*NP-1:0] pad_owner_o;
  logic          conflict_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  pinsel_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_claimed_o(pad_claimed_o),
    .pad_owner_o(pad_owner_o), .conflict_o(conflict_o)
  );

  // {written value, expected readback}
  localparam logic [15:0] VEC [10] = '{
    16'h01_01, 16'h02_02, 16'h03_03, 16'h04_04, 16'h08_08,
    16'h0C_0C, 16'h09_09, 16'h0A_0A, 16'hF5_05, 16'h00_00
  };

  function automatic logic [1:0] exp_owner(logic [7:0] s, int p);
    if (s[1:0] == 2'd1 && (p == 83 || p == 84 || p == 86 || p == 87)) return 2'd1;
    if (s[1:0] == 2'd2 && (p == 76 || p == 78 || p == 79 || p == 81)) return 2'd1;
    if (s[2] && (p == 88 || p == 89)) return 2'd2;
    if (s[3] && p >= 72 && p <= 81) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 2'd0;
  endtask

  task automatic check_pads(string req, logic [7:0] s);
    logic [NP-1:0]   ec;
    logic [2*NP-1:0] eo;
    for (int p = 0; p < NP; p++) begin
      eo[2*p +: 2] = exp_owner(s, p);
      ec[p] = (exp_owner(s, p) != 2'd0);
    end
    check({req, " claimed"}, 256'(pad_claimed_o), 256'(ec));
    check({req, " owner"}, 256'(pad_owner_o), 256'(eo));
  endtask

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00;
    repeat (3) @(negedge clk_i);
    // R1: values while reset is held
    check("R1 claimed in reset", 256'(pad_claimed_o), 256'(0));
    check("R1 conflict in reset", 256'(conflict_o), 256'(0));
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 select readback", 256'(rdata_o), 256'(0));
    check_pads("R1", 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][15:8]);
      check("R11 readback", 256'(rdata_o), 256'(VEC[i][7:0]));
      @(negedge clk_i);
      check_pads("R2/R3/R4/R5/R6/R7 table", VEC[i][7:0]);
    end

    // R10: readback first, pads one edge later
    wr(2'd0, 8'h04);
    check("R10 readback after capture", 256'(rdata_o), 256'(8'h04));
    check("R10 pad not yet claimed", 256'(pad_claimed_o[88]), 256'(0));
    @(negedge clk_i);
    check("R10 pad claimed next edge", 256'(pad_claimed_o[88]), 256'(1));

    // R11: unmapped addresses ignored
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    addr_i = 2'd2; #0;
    check("R11 unmapped read", 256'(rdata_o), 256'(0));
    addr_i = 2'd0;
    @(negedge clk_i);
    check("R11 select kept", 256'(rdata_o), 256'(8'h04));
    check_pads("R11 pads kept", 8'h04);

    // R8: sticky conflict
    wr(2'd1, 8'h01);
    addr_i = 2'd1; #0;
    check("R8 flag clear before overlap", 256'(conflict_o), 256'(0));
    wr(2'd0, 8'h0A);
    check("R8 not yet set at select capture", 256'(conflict_o), 256'(0));
    @(negedge clk_i);
    check("R8 set with pad update", 256'(conflict_o), 256'(1));
    addr_i = 2'd1; #0;
    check("R8 status bit", 256'(rdata_o), 256'(1));
    wr(2'd0, 8'h00);
    @(negedge clk_i);
    check("R8 held after overlap removed", 256'(conflict_o), 256'(1));

    // R9: clear semantics
    wr(2'd1, 8'h00);
    check("R9 write zero no effect", 256'(conflict_o), 256'(1));
    wr(2'd1, 8'h01);
    check("R9 write one clears", 256'(conflict_o), 256'(0));
    wr(2'd0, 8'h0A);
    @(negedge clk_i);
    wr(2'd1, 8'h01);
    check("R9 set dominates clear", 256'(conflict_o), 256'(1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule